// File: doc/BRIEF.md
# Phased Instruction Control Sequencer

This block steers a small 16-bit CPU that has eight registers and instructions of one or two words. It keeps a phase counter that steps through fetch, an optional constant-fetch phase and execute. It also holds a one-bit interrupt-active flag and the program counter. In every cycle it turns the held instruction word, the constant-needed bit seen on the memory data bus, the zero flag of register channel A, the interrupt request and reset into datapath controls: register addresses, register write enable and data source, ALU operand sources, memory write and address source, instruction-register load, and the next-PC choice.

A one-word instruction takes two cycles: fetch, then execute. A two-word instruction takes three, because the extra phase fetches its constant. An interrupt is taken only at a fetch boundary. When it is taken, the current PC is saved in a fixed register and execution moves to the interrupt vector. A jump that reads its target from that same register ends the interrupt. The register file, the ALU and the memory are outside this block. The ALU result comes back in as the jump target.

Top module: `cpu_ctl_seq`

## Requirements
- R1: While reset is high, register write enable and memory write are 0 and the next-PC select is 2 (vector). After an edge with reset high, the phase is 0, the interrupt flag is 0 and the PC is 0xFD00.
- R2: In phase 0 (no interrupt taken), the instruction-register load is 1. If the constant-needed input is 1, the next-PC select is 1, the PC advances by 2 and the next phase is 1. If it is 0, the select is 0, the PC holds and the next phase is 2.
- R3: In phase 1, the instruction-register load is 0, the next-PC select is 0 (PC held) and the next phase is 2.
- R4: Phase 2 is always followed by phase 0. In phase 2 an ALU instruction (bit 9 = 0) writes Rc with the ALU result (source select 1), takes channel B from Rb, takes operand B from the constant exactly when bit 10 is 1, and advances the PC by 2.
- R5: The ALU function output equals instruction bits 15:11, and the Ra address equals bits 2:0, in every phase.
- R6: LD (bit 9 = 1, bits 8:6 = 010) and LDR (110) write Rc from memory data (source select 2), address memory from the ALU result and take operand B from the constant. LDR takes operand A from PC+2, LD from the register.
- R7: ST (sub-code 011) raises memory write, writes no register, drives the channel-B address from Rc (bits 5:3), and addresses memory from the ALU result.
- R8: BEQ (100) and BNE (101) write PC+2 into Rc (source select 0) and use PC+2 and the constant as ALU operands. The next-PC select is 3 (jump) when BEQ sees zero or BNE sees non-zero; otherwise it is 1.
- R9: JMP (000) writes PC+2 into Rc and selects 3. The PC then loads the jump target with bit 0 forced to 0.
- R10: An interrupt is taken in phase 0 when the request is high, reset is low and the flag is clear. In that cycle R6 is written from the PC (source select 3), the instruction register does not load and the select is 2. On the next edge the flag sets, the PC becomes 0xFE00 and the phase stays 0.
- R11: An interrupt request is ignored while the flag is set or in phases 1 and 2. No write occurs, the PC follows the normal sequence and the flag is unchanged.
- R12: A JMP whose Ra is 6 clears the interrupt flag. A JMP through any other register leaves it set.
- R13: Sub-codes 001 and 111 write neither a register nor memory, and advance the PC by 2.
- R14: The PC+2 output equals the PC plus 2 modulo 2^16, so 0xFFFE is followed by 0x0000. The PC's bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, also decoded into the controls |
| irq | input | 1 | Interrupt request |
| cn_in | input | 1 | Constant-needed bit from the memory data bus |
| instr | input | 16 | Instruction register contents |
| zero_a | input | 1 | Register channel A equals zero |
| jump_tgt | input | 16 | Jump target (ALU result) |
| phase | output | 2 | Current phase: 0 fetch, 1 constant, 2 execute |
| irq_flag | output | 1 | Interrupt-active flag |
| ir_load | output | 1 | Instruction-register load enable |
| alu_fn | output | 5 | ALU function code |
| ra_addr | output | 3 | Register channel A address |
| rb_addr | output | 3 | Register channel B address (Rb or Rc) |
| wr_addr | output | 3 | Register write address (Rc or R6) |
| rf_we | output | 1 | Register write enable |
| wd_sel | output | 2 | Write data source: 0 PC+2, 1 ALU, 2 memory, 3 PC |
| alu_asel | output | 1 | Operand A: 0 register, 1 PC+2 |
| alu_bsel | output | 1 | Operand B: 0 register, 1 constant |
| mem_we | output | 1 | Memory write enable |
| mem_asel | output | 1 | Memory address: 0 PC, 1 ALU result |
| pc_sel | output | 2 | Next PC: 0 hold, 1 +2, 2 vector, 3 jump |
| pc | output | 16 | Program counter |
| pc_inc | output | 16 | Program counter plus 2 |

## Verification
The bench builds the block with its defaults: a 16-bit program counter, vectors 0xFD00 and 0xFE00, R6 as the interrupt register and the ripple incrementer. With 16 bits, a jump to the top word puts the 0xFFFE-to-0x0000 wrap two cycles away, which checks the carry chain at its full length. Fixing the interrupt register at 6 makes the flag-clearing jump and the saved-address write visible on the write-address port. Both vector values show up directly on the PC after a reset and after an accepted interrupt.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;

   localparam int OP_W     = 16;
   localparam int REG_AW   = 3;
   localparam int NUM_REGS = 1 << REG_AW;
   localparam int FN_W     = 5;

   localparam int FN_HI  = 15;
   localparam int FN_LO  = FN_HI - FN_W + 1;
   localparam int CN_BIT = 10;
   localparam int NA_BIT = 9;
   localparam int SUB_HI = 8;
   localparam int SUB_LO = SUB_HI - REG_AW + 1;
   localparam int RC_HI  = 5;
   localparam int RC_LO  = RC_HI - REG_AW + 1;
   localparam int RA_HI  = 2;
   localparam int RA_LO  = 0;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_CONST = 2'd1,
      PH_EXEC  = 2'd2
   } phase_e;

   typedef enum logic [2:0] {
      SUB_JMP = 3'b000,
      SUB_U1  = 3'b001,
      SUB_LD  = 3'b010,
      SUB_ST  = 3'b011,
      SUB_BEQ = 3'b100,
      SUB_BNE = 3'b101,
      SUB_LDR = 3'b110,
      SUB_U7  = 3'b111
   } subop_e;

   typedef enum logic [1:0] {
      PCS_HOLD = 2'd0,
      PCS_INC  = 2'd1,
      PCS_VEC  = 2'd2,
      PCS_JUMP = 2'd3
   } pcsel_e;

   typedef enum logic [1:0] {
      WD_PCINC = 2'd0,
      WD_ALU   = 2'd1,
      WD_MEM   = 2'd2,
      WD_PC    = 2'd3
   } wdsel_e;

   typedef struct packed {
      logic   wr_en;
      logic   wa_exc;
      logic   rb_from_rc;
      logic   asel_pc;
      logic   bsel_const;
      logic   mem_we;
      logic   mem_asel;
      logic   ir_load;
      pcsel_e pc_sel;
      wdsel_e wd_sel;
   } ctl_t;

endpackage

// File: rtl/ctl_phase_fsm.sv
module ctl_phase_fsm
   import cpu_ctl_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   irq,
   input  logic   cn,
   input  logic   flag_clr,
   output phase_e phase,
   output logic   iflag,
   output logic   irq_take
);

   phase_e phase_q, phase_d;
   logic   iflag_q, iflag_d;

   assign irq_take = (phase_q == PH_FETCH) && irq && !rst && !iflag_q;

   always_comb begin
      phase_d = phase_q;
      if (rst || irq_take) begin
         phase_d = PH_FETCH;
      end else begin
         case (phase_q)
            PH_FETCH: phase_d = cn ? PH_CONST : PH_EXEC;
            PH_CONST: phase_d = PH_EXEC;
            default:  phase_d = PH_FETCH;
         endcase
      end
   end

   always_comb begin
      iflag_d = iflag_q;
      if (rst)           iflag_d = 1'b0;
      else if (irq_take) iflag_d = 1'b1;
      else if (flag_clr) iflag_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      phase_q <= phase_d;
      iflag_q <= iflag_d;
   end

   assign phase = phase_q;
   assign iflag = iflag_q;

   assert_fetch_next_R2: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_FETCH && !irq_take) |=>
         (phase_q == ($past(cn) ? PH_CONST : PH_EXEC)));

   assert_const_to_exec_R3: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_CONST) |=> (phase_q == PH_EXEC));

   assert_exec_to_fetch_R4: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));

   assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
      irq_take |=> iflag_q);

   assert_flag_kept_R11: assert property (@(posedge clk) disable iff (rst)
      (iflag_q && !flag_clr) |=> iflag_q);

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
   import cpu_ctl_pkg::*;
#(
   parameter int IRQ_REG = 6
)(
   input  logic               clk,
   input  logic               rst,
   input  phase_e             phase,
   input  logic               irq_take,
   input  logic               cn,
   input  logic               zero_a,
   input  logic [OP_W-1:0]    instr,
   output ctl_t               ctl,
   output logic               flag_clr,
   output logic [FN_W-1:0]    alu_fn,
   output logic [REG_AW-1:0]  ra_addr,
   output logic [REG_AW-1:0]  rb_addr,
   output logic [REG_AW-1:0]  wr_addr
);

   localparam logic [REG_AW-1:0] IRQ_ADDR = REG_AW'(IRQ_REG);

   if (IRQ_REG < 0 || IRQ_REG >= NUM_REGS) begin : g_bad_irq_reg
      $error("IRQ_REG outside the register file");
   end

   logic [REG_AW-1:0] f_ra, f_rb, f_rc;
   subop_e            sub;
   logic              taken;

   assign f_ra   = instr[RA_HI:RA_LO];
   assign f_rb   = instr[SUB_HI:SUB_LO];
   assign f_rc   = instr[RC_HI:RC_LO];
   assign sub    = subop_e'(instr[SUB_HI:SUB_LO]);
   assign alu_fn = instr[FN_HI:FN_LO];
   assign taken  = (sub == SUB_BEQ) ? zero_a : !zero_a;

   always_comb begin
      ctl            = '0;
      ctl.pc_sel     = PCS_HOLD;
      ctl.wd_sel     = WD_ALU;
      ctl.bsel_const = instr[CN_BIT];
      flag_clr       = 1'b0;
      if (rst) begin
         ctl.bsel_const = 1'b0;
         ctl.pc_sel     = PCS_VEC;
      end else if (irq_take) begin
         ctl.wr_en  = 1'b1;
         ctl.wa_exc = 1'b1;
         ctl.wd_sel = WD_PC;
         ctl.pc_sel = PCS_VEC;
      end else begin
         case (phase)
            PH_FETCH: begin
               ctl.ir_load = 1'b1;
               ctl.pc_sel  = cn ? PCS_INC : PCS_HOLD;
            end
            PH_CONST: ctl.pc_sel = PCS_HOLD;
            PH_EXEC: begin
               ctl.pc_sel = PCS_INC;
               if (!instr[NA_BIT]) begin
                  ctl.wr_en = 1'b1;
               end else begin
                  case (sub)
                     SUB_JMP: begin
                        ctl.wr_en  = 1'b1;
                        ctl.wd_sel = WD_PCINC;
                        ctl.pc_sel = PCS_JUMP;
                        flag_clr   = (f_ra == IRQ_ADDR);
                     end
                     SUB_LD: begin
                        ctl.wr_en      = 1'b1;
                        ctl.wd_sel     = WD_MEM;
                        ctl.bsel_const = 1'b1;
                        ctl.mem_asel   = 1'b1;
                     end
                     SUB_LDR: begin
                        ctl.wr_en      = 1'b1;
                        ctl.wd_sel     = WD_MEM;
                        ctl.asel_pc    = 1'b1;
                        ctl.bsel_const = 1'b1;
                        ctl.mem_asel   = 1'b1;
                     end
                     SUB_ST: begin
                        ctl.mem_we     = 1'b1;
                        ctl.rb_from_rc = 1'b1;
                        ctl.bsel_const = 1'b1;
                        ctl.mem_asel   = 1'b1;
                     end
                     SUB_BEQ, SUB_BNE: begin
                        ctl.wr_en      = 1'b1;
                        ctl.wd_sel     = WD_PCINC;
                        ctl.asel_pc    = 1'b1;
                        ctl.bsel_const = 1'b1;
                        ctl.pc_sel     = taken ? PCS_JUMP : PCS_INC;
                     end
                     default: ctl.pc_sel = PCS_INC;
                  endcase
               end
            end
            default: ctl.pc_sel = PCS_HOLD;
         endcase
      end
   end

   assign ra_addr = f_ra;
   assign rb_addr = ctl.rb_from_rc ? f_rc : f_rb;
   assign wr_addr = ctl.wa_exc ? IRQ_ADDR : f_rc;

   assert_store_path_R7: assert property (@(posedge clk) disable iff (rst)
      ctl.mem_we |-> (!ctl.wr_en && ctl.mem_asel && rb_addr == instr[RC_HI:RC_LO]));

   assert_irq_save_R10: assert property (@(posedge clk) disable iff (rst)
      irq_take |-> (ctl.wr_en && wr_addr == IRQ_ADDR && ctl.pc_sel == PCS_VEC
                    && !ctl.ir_load));

   assert_const_phase_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_CONST) |-> (!ctl.wr_en && !ctl.mem_we && ctl.pc_sel == PCS_HOLD));

endmodule

// File: rtl/ctl_pc_unit.sv
module ctl_pc_unit
   import cpu_ctl_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] RST_VEC  = 16'hFD00,
   parameter logic [ADDR_W-1:0] IRQ_VEC  = 16'hFE00,
   parameter bit              INC_RIPPLE = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  pcsel_e            pc_sel,
   input  logic              vec_irq,
   input  logic [ADDR_W-1:0] jump_tgt,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] pc_inc
);

   localparam int              HI_W      = ADDR_W - 1;
   localparam logic [ADDR_W-1:0] EVEN_MASK = {{HI_W{1'b1}}, 1'b0};

   if (ADDR_W < 2) begin : g_bad_width
      $error("ADDR_W must be at least 2");
   end
   if (RST_VEC[0] || IRQ_VEC[0]) begin : g_bad_vec
      $error("vectors must be word aligned");
   end

   logic [ADDR_W-1:0] pc_q, pc_nxt, pc_d, vec;
   logic [HI_W-1:0]   hi_inc;

   if (INC_RIPPLE) begin : g_ripple
      always_comb begin
         logic c;
         c = 1'b1;
         for (int i = 0; i < HI_W; i++) begin
            hi_inc[i] = pc_q[i+1] ^ c;
            c         = pc_q[i+1] & c;
         end
      end
   end else begin : g_adder
      assign hi_inc = pc_q[ADDR_W-1:1] + HI_W'(1);
   end

   assign pc_inc = {hi_inc, pc_q[0]};
   assign vec    = vec_irq ? IRQ_VEC : RST_VEC;

   always_comb begin
      case (pc_sel)
         PCS_HOLD: pc_nxt = pc_q;
         PCS_INC:  pc_nxt = pc_inc;
         PCS_VEC:  pc_nxt = vec;
         default:  pc_nxt = jump_tgt;
      endcase
      pc_d = pc_nxt & EVEN_MASK;
   end

   always_ff @(posedge clk) begin
      pc_q <= pc_d;
   end

   assign pc = pc_q;

   assert_pc_advance_R14: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == PCS_INC) |=> (pc_q == $past(pc_q) + ADDR_W'(2)));

   assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == PCS_HOLD) |=> $stable(pc_q));

   assert_jump_even_R9: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == PCS_JUMP) |=> (pc_q == ($past(jump_tgt) & EVEN_MASK)));

endmodule

// File: rtl/cpu_ctl_seq.sv
module cpu_ctl_seq
   import cpu_ctl_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFD00,
   parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFE00,
   parameter int                IRQ_REG    = 6,
   parameter bit                INC_RIPPLE = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              irq,
   input  logic              cn_in,
   input  logic [15:0]       instr,
   input  logic              zero_a,
   input  logic [ADDR_W-1:0] jump_tgt,
   output logic [1:0]        phase,
   output logic              irq_flag,
   output logic              ir_load,
   output logic [4:0]        alu_fn,
   output logic [2:0]        ra_addr,
   output logic [2:0]        rb_addr,
   output logic [2:0]        wr_addr,
   output logic              rf_we,
   output logic [1:0]        wd_sel,
   output logic              alu_asel,
   output logic              alu_bsel,
   output logic              mem_we,
   output logic              mem_asel,
   output logic [1:0]        pc_sel,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] pc_inc
);

   phase_e ph;
   logic   iflag, irq_take, flag_clr;
   ctl_t   ctl;

   ctl_phase_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .irq      (irq),
      .cn       (cn_in),
      .flag_clr (flag_clr),
      .phase    (ph),
      .iflag    (iflag),
      .irq_take (irq_take)
   );

   ctl_decode #(.IRQ_REG(IRQ_REG)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .phase    (ph),
      .irq_take (irq_take),
      .cn       (cn_in),
      .zero_a   (zero_a),
      .instr    (instr),
      .ctl      (ctl),
      .flag_clr (flag_clr),
      .alu_fn   (alu_fn),
      .ra_addr  (ra_addr),
      .rb_addr  (rb_addr),
      .wr_addr  (wr_addr)
   );

   ctl_pc_unit #(
      .ADDR_W     (ADDR_W),
      .RST_VEC    (RST_VEC),
      .IRQ_VEC    (IRQ_VEC),
      .INC_RIPPLE (INC_RIPPLE)
   ) u_pc (
      .clk      (clk),
      .rst      (rst),
      .pc_sel   (ctl.pc_sel),
      .vec_irq  (irq & ~rst),
      .jump_tgt (jump_tgt),
      .pc       (pc),
      .pc_inc   (pc_inc)
   );

   assign phase    = ph;
   assign irq_flag = iflag;
   assign ir_load  = ctl.ir_load;
   assign rf_we    = ctl.wr_en;
   assign wd_sel   = ctl.wd_sel;
   assign alu_asel = ctl.asel_pc;
   assign alu_bsel = ctl.bsel_const;
   assign mem_we   = ctl.mem_we;
   assign mem_asel = ctl.mem_asel;
   assign pc_sel   = ctl.pc_sel;

   assert_irq_vector_R10: assert property (@(posedge clk) disable iff (rst)
      irq_take |=> (pc == IRQ_VEC && phase == 2'd0));

   assert_r6_jump_clears_R12: assert property (@(posedge clk) disable iff (rst)
      flag_clr |=> !irq_flag);

endmodule

// File: tb/cpu_ctl_seq_bench.sv
module cpu_ctl_seq_bench;

   typedef struct packed {
      logic [15:0] instr;
      logic        zero;
      logic [15:0] jt;
      logic        we;
      logic        mw;
      logic [1:0]  wd;
      logic [1:0]  ps;
      logic        as_;
      logic        bs;
      logic        ma;
      logic [2:0]  rb;
      logic [2:0]  wa;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{16'h00CA, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd3, 3'd1, 8'd4},  // R4 ADD
      '{16'h0425, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd4, 8'd4},  // R4 ADD with constant
      '{16'hB087, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 8'd5},  // R5 other function code
      '{16'h0691, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 8'd6},  // R6 LD
      '{16'h07B0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 3'd6, 3'd6, 8'd6},  // R6 LDR
      '{16'h06FB, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 3'd7, 3'd7, 8'd7},  // R7 ST
      '{16'h0728, 1'b1, 16'h1235, 1'b1, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 3'd4, 3'd5, 8'd8},  // R8 BEQ taken
      '{16'h0728, 1'b0, 16'h3000, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 3'd4, 3'd5, 8'd8},  // R8 BEQ not taken
      '{16'h0768, 1'b0, 16'h2000, 1'b1, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 3'd5, 3'd5, 8'd8},  // R8 BNE taken
      '{16'h0768, 1'b1, 16'h5000, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 3'd5, 3'd5, 8'd8},  // R8 BNE not taken
      '{16'h0219, 1'b0, 16'h4002, 1'b1, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 3'd3, 8'd9},  // R9 JMP through R1
      '{16'h0253, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 8'd13}, // R13 code 001
      '{16'h07C1, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 3'd7, 3'd0, 8'd13}  // R13 code 111
   };

   // R12 jump through R6, R9 jump to an odd top address
   localparam vec_t JMP6 =
      '{16'h0206, 1'b0, 16'h0100, 1'b1, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'd12};
   localparam vec_t JTOP =
      '{16'h0219, 1'b0, 16'hFFFF, 1'b1, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 3'd3, 8'd9};

   logic        clk = 1'b0;
   logic        rst, irq, cn_in, zero_a;
   logic [15:0] instr, jump_tgt;
   logic [1:0]  phase, wd_sel, pc_sel;
   logic        irq_flag, ir_load, rf_we, alu_asel, alu_bsel, mem_we, mem_asel;
   logic [4:0]  alu_fn;
   logic [2:0]  ra_addr, rb_addr, wr_addr;
   logic [15:0] pc, pc_inc;

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;
   logic [15:0] exp_pc;

   always #4 clk = ~clk;

   cpu_ctl_seq u_cpu_ctl_seq (
      .clk(clk), .rst(rst), .irq(irq), .cn_in(cn_in), .instr(instr),
      .zero_a(zero_a), .jump_tgt(jump_tgt), .phase(phase), .irq_flag(irq_flag),
      .ir_load(ir_load), .alu_fn(alu_fn), .ra_addr(ra_addr), .rb_addr(rb_addr),
      .wr_addr(wr_addr), .rf_we(rf_we), .wd_sel(wd_sel), .alu_asel(alu_asel),
      .alu_bsel(alu_bsel), .mem_we(mem_we), .mem_asel(mem_asel), .pc_sel(pc_sel),
      .pc(pc), .pc_inc(pc_inc)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Runs one instruction from phase 0; starts and ends just after a falling edge.
   task automatic run_vec(input vec_t v, input logic irq_lvl);
      string       rq;
      logic [15:0] inc_exp;
      rq      = $sformatf("R%0d", v.req);
      irq     = irq_lvl;
      cn_in   = v.instr[10];
      instr   = v.instr;
      zero_a  = 1'b0;
      #1;
      inc_exp = exp_pc + 16'd2;
      chk("R2", "fetch phase", phase, 0);
      chk("R2", "ir_load in fetch", ir_load, 1);
      chk("R2", "pc_sel in fetch", pc_sel, {1'b0, v.instr[10]});
      chk("R2", "no write in fetch", {rf_we, mem_we}, 0);
      chk("R14", "pc", pc, exp_pc);
      chk("R14", "pc_inc", pc_inc, inc_exp);
      @(negedge clk);
      if (v.instr[10]) begin
         exp_pc = exp_pc + 16'd2;
         cn_in  = 1'b0;
         #1;
         chk("R3", "const phase", phase, 1);
         chk("R3", "ir_load in const", ir_load, 0);
         chk("R3", "pc_sel in const", pc_sel, 0);
         chk("R2", "pc after constant fetch", pc, exp_pc);
         @(negedge clk);
      end else begin
         chk("R2", "pc held in one-word fetch", pc, exp_pc);
      end
      cn_in    = 1'b0;
      zero_a   = v.zero;
      jump_tgt = v.jt;
      #1;
      chk("R4", "exec phase", phase, 2);
      chk("R5", "alu_fn", alu_fn, v.instr[15:11]);
      chk("R5", "ra_addr", ra_addr, v.instr[2:0]);
      chk(rq, "rf_we", rf_we, v.we);
      chk(rq, "mem_we", mem_we, v.mw);
      if (v.we) chk(rq, "wd_sel", wd_sel, v.wd);
      chk(rq, "pc_sel", pc_sel, v.ps);
      chk(rq, "alu_asel", alu_asel, v.as_);
      chk(rq, "alu_bsel", alu_bsel, v.bs);
      chk(rq, "mem_asel", mem_asel, v.ma);
      chk(rq, "rb_addr", rb_addr, v.rb);
      chk(rq, "wr_addr", wr_addr, v.wa);
      chk(rq, "ir_load in exec", ir_load, 0);
      @(negedge clk);
      if (v.ps == 2'd3) exp_pc = v.jt & 16'hFFFE;
      else              exp_pc = exp_pc + 16'd2;
      chk("R4", "back to fetch", phase, 0);
      chk(rq, "pc after exec", pc, exp_pc);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      rst = 1'b1; irq = 1'b0; cn_in = 1'b0; zero_a = 1'b0;
      instr = 16'h06FB; jump_tgt = 16'h0000;
      repeat (2) @(negedge clk);
      // R1: controls while reset is held
      #1;
      chk("R1", "rf_we in reset", rf_we, 0);
      chk("R1", "mem_we in reset", mem_we, 0);
      chk("R1", "pc_sel in reset", pc_sel, 2);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1", "pc after reset", pc, 16'hFD00);
      chk("R1", "phase after reset", phase, 0);
      chk("R1", "flag after reset", irq_flag, 0);
      exp_pc = 16'hFD00;

      for (int i = 0; i < NV; i++) run_vec(TBL[i], 1'b0);

      // R10: interrupt accepted at a fetch boundary
      irq = 1'b1; cn_in = 1'b0; instr = 16'h00CA;
      #1;
      chk("R10", "rf_we on irq", rf_we, 1);
      chk("R10", "wr_addr on irq", wr_addr, 6);
      chk("R10", "wd_sel on irq", wd_sel, 3);
      chk("R10", "pc_sel on irq", pc_sel, 2);
      chk("R10", "ir_load on irq", ir_load, 0);
      chk("R10", "mem_we on irq", mem_we, 0);
      @(negedge clk);
      #1;
      chk("R10", "flag set", irq_flag, 1);
      chk("R10", "pc at irq vector", pc, 16'hFE00);
      chk("R10", "phase stays 0", phase, 0);
      exp_pc = 16'hFE00;

      // R11: request held high while the flag is set
      run_vec(TBL[1], 1'b1);
      chk("R11", "flag unchanged", irq_flag, 1);
      // R12: jump through R1 leaves the flag
      run_vec(TBL[10], 1'b1);
      chk("R12", "flag kept after JMP R1", irq_flag, 1);
      // R12: jump through R6 clears it
      run_vec(JMP6, 1'b0);
      chk("R12", "flag cleared by JMP R6", irq_flag, 0);

      // R11: request in phase 1 with the flag clear
      irq = 1'b0; cn_in = 1'b1; instr = 16'h0425;
      @(negedge clk);
      exp_pc = exp_pc + 16'd2;
      irq = 1'b1; cn_in = 1'b0;
      #1;
      chk("R11", "pc_sel with irq in const", pc_sel, 0);
      chk("R11", "rf_we with irq in const", rf_we, 0);
      @(negedge clk);
      irq = 1'b0;
      #1;
      chk("R11", "flag after irq in const", irq_flag, 0);
      chk("R11", "phase after irq in const", phase, 2);
      @(negedge clk);
      exp_pc = exp_pc + 16'd2;
      chk("R11", "pc after ignored irq", pc, exp_pc);

      // R9 and R14: jump to the top word, then wrap
      run_vec(JTOP, 1'b0);
      chk("R9", "bit 0 cleared", pc, 16'hFFFE);
      chk("R14", "pc_inc wraps", pc_inc, 16'h0000);
      run_vec(TBL[1], 1'b0);
      chk("R14", "pc after wrap", pc, 16'h0002);

      // R1: reset during a store execute, with the flag set
      irq = 1'b1; cn_in = 1'b0;
      @(negedge clk);
      exp_pc = 16'hFE00;
      irq = 1'b0; cn_in = 1'b1; instr = 16'h06FB;
      @(negedge clk);
      cn_in = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      #1;
      chk("R1", "mem_we blocked by reset", mem_we, 0);
      chk("R1", "rf_we blocked by reset", rf_we, 0);
      chk("R1", "pc_sel under reset", pc_sel, 2);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1", "pc reloaded", pc, 16'hFD00);
      chk("R1", "phase reloaded", phase, 0);
      chk("R1", "flag cleared by reset", irq_flag, 0);

      summary();
   end

endmodule